// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a physical address. It uses a small set of programmable block mappings and does not walk any page table. It has two banks of four mapping entries each. One bank serves instruction fetches and the other serves data accesses. Each entry is a pair of 32-bit registers. The upper register describes which address block is covered, how large the block is, and in which privilege modes the entry is usable. The lower register gives the physical block base and the access rights.

Software programs the pairs through a simple register port. A write to an upper register trims the stored block bits to the block size just written. It also trims the paired lower register in the same way. A lookup request carries the address, the access type (code or data), a write flag and a user-mode flag. The registered response arrives one cycle later. It gives a hit flag, the physical page address, the read and write rights, and a protection-fault flag. When translation is switched off for the access type, the address passes straight through with full rights.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset every mapping register reads as zero, and rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_rd_o, rsp_wr_o and rsp_paddr_o are zero.
- R2: cfg_rdata_o shows, without delay, the stored register that is selected by cfg_bank_i (1 = instruction bank, 0 = data bank), cfg_idx_i and cfg_lower_i (1 = lower register). A write to a lower register stores the written value unchanged.
- R3: Writing an upper register works as follows. The length mask L is written bits 12:2 placed on bits 27:17, so written bit 2+k masks bit 17+k. The stored upper value keeps bits 12:0, clears bits 16:13, and clears bits 27:17 wherever L is set. In the same cycle the paired lower register keeps its bits 31:28, bits 6:3 and bits 1:0. It clears bits 27:17 wherever L is set, and clears the rest of its bits 16:0.
- R4: An entry matches when address bits 31:28 equal upper bits 31:28. It also needs address bits 27:17, with the mask bits cleared, to equal upper bits 27:17.
- R5: A matching entry is usable only if upper bit 1 is set for a supervisor access (req_user_i = 0), or upper bit 0 is set for a user access.
- R6: On a hit the physical address is built as follows. Bits 31:28 come from the lower register. Bits 27:17 are (address AND L) OR lower bits 27:17. Bits 16:12 come from the address. Bits 11:0 are zero.
- R7: Lower bit 1 set gives read and write. Otherwise lower bit 0 set gives read only. With neither bit set there are no rights.
- R8: When several entries are usable for an address, the lowest-numbered entry supplies the result.
- R9: A hit whose rights do not cover the access (a write without write right, or a read without read right) reports rsp_hit_o = 1 and rsp_fault_o = 1.
- R10: With no usable entry, rsp_hit_o, rsp_fault_o, rsp_rd_o and rsp_wr_o are 0 and rsp_paddr_o is zero.
- R11: Instruction lookups (req_code_i = 1) use the instruction bank and xlat_ir_en_i. Data lookups use the data bank and xlat_dr_en_i. With that enable low, the result is a hit with read and write rights, no fault, and the address with bits 11:0 cleared.
- R12: rsp_valid_o is high exactly in the cycle after a cycle with req_i high. The other response outputs keep their value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_bank_i | input | 1 | Bank select, 1 = instruction, 0 = data |
| cfg_idx_i | input | 2 | Entry index |
| cfg_lower_i | input | 1 | 1 = lower register, 0 = upper register |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Selected register contents |
| xlat_ir_en_i | input | 1 | Translation enable for instruction fetches |
| xlat_dr_en_i | input | 1 | Translation enable for data accesses |
| req_i | input | 1 | Lookup strobe |
| req_addr_i | input | 32 | Effective address |
| req_code_i | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write_i | input | 1 | 1 = write access |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid_o | output | 1 | Response valid, one cycle after req_i |
| rsp_hit_o | output | 1 | A usable mapping was found, or translation is off |
| rsp_fault_o | output | 1 | Protection violation on a hit |
| rsp_rd_o | output | 1 | Read allowed |
| rsp_wr_o | output | 1 | Write allowed |
| rsp_paddr_o | output | 32 | Physical page address, bits 11:0 zero |

## Verification
The bench programs entries with a mix of block lengths, from no mask to the full 11-bit mask. Their block bases sit close to one another, so neighbouring addresses fall into several entries at once and priority is exercised. A unit that picked the highest entry, or ignored the privilege bits, would return the wrong physical base or a false hit.

Every write is followed by a read-back. This catches a unit that fails to trim the upper or lower register on an upper write, or trims a lower register on its own write. That fault would show up later as a stale physical bit on a hit.

Addresses are varied both inside and outside the masked bits. This separates correct masking from a compare that uses every bit of 27:17. The translation enables are toggled independently of the access type, which catches a unit that consults the wrong bank or the wrong enable.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam int unsigned XW = 32;
  // Bits of a written upper value that survive apart from the block field
  localparam logic [XW-1:0] UP_KEEP  = 32'h0000_1FFF;
  // Low control bits of a lower register preserved by an upper write
  localparam logic [XW-1:0] LO_KEEP  = 32'h0000_007B;
  localparam logic [XW-1:0] BLK_HIGH = 32'hFFFE_0000;

  typedef struct packed {
    logic          hit;
    logic          rd;
    logic          wr;
    logic [XW-1:0] paddr;
  } xlat_res_t;

  function automatic logic [XW-1:0] len_mask(input logic [XW-1:0] upper);
    return {4'b0, upper[12:2], 17'b0};
  endfunction
endpackage

// File: rtl/blk_xlate_bank.sv
module blk_xlate_bank
  import blk_xlate_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      lower_i,
  input  logic [XW-1:0]             wdata_i,
  output logic [N_ENT-1:0][XW-1:0]  upper_o,
  output logic [N_ENT-1:0][XW-1:0]  lower_o
);
  logic [N_ENT-1:0][XW-1:0] upper_q, lower_q;
  logic [XW-1:0] wmask;

  assign wmask = len_mask(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      lower_q <= '0;
    end else if (we_i) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (idx_i == IDX_W'(e)) begin
          if (lower_i) begin
            lower_q[e] <= wdata_i;
          end else begin
            upper_q[e] <= (wdata_i & UP_KEEP) | (wdata_i & BLK_HIGH & ~wmask);
            lower_q[e] <= (lower_q[e] & LO_KEEP) | (lower_q[e] & BLK_HIGH & ~wmask);
          end
        end
      end
    end
  end

  assign upper_o = upper_q;
  assign lower_o = lower_q;
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry
  import blk_xlate_pkg::*;
(
  input  logic [XW-1:0] upper_i,
  input  logic [XW-1:0] lower_i,
  input  logic [XW-1:0] addr_i,
  input  logic          user_i,
  output logic          hit_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [XW-1:0] paddr_o
);
  logic [10:0] bl;
  logic        tag_ok, priv_ok;
  logic        unused_bits;

  assign bl      = upper_i[12:2];
  assign tag_ok  = (addr_i[31:28] == upper_i[31:28]) &&
                   ((addr_i[27:17] & ~bl) == upper_i[27:17]);
  assign priv_ok = user_i ? upper_i[0] : upper_i[1];
  assign hit_o   = tag_ok && priv_ok;
  assign wr_o    = lower_i[1];
  assign rd_o    = lower_i[1] | lower_i[0];
  assign paddr_o = {lower_i[31:28], (addr_i[27:17] & bl) | lower_i[27:17],
                    addr_i[16:12], 12'h000};

  assign unused_bits = ^{upper_i[16:13], lower_i[16:2], addr_i[11:0]};
endmodule

// File: rtl/blk_xlate_select.sv
module blk_xlate_select
  import blk_xlate_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  logic [N_ENT-1:0]          hit_i,
  input  logic [N_ENT-1:0]          rd_i,
  input  logic [N_ENT-1:0]          wr_i,
  input  logic [N_ENT-1:0][XW-1:0]  paddr_i,
  output xlat_res_t                 res_o
);
  // Scan downward so the lowest index is assigned last and wins
  always_comb begin
    res_o = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hit_i[e]) begin
        res_o.hit   = 1'b1;
        res_o.rd    = rd_i[e];
        res_o.wr    = wr_i[e];
        res_o.paddr = paddr_i[e];
      end
    end
  end
endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
  import blk_xlate_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_bank_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_lower_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              xlat_ir_en_i,
  input  logic              xlat_dr_en_i,
  input  logic              req_i,
  input  logic [31:0]       req_addr_i,
  input  logic              req_code_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_fault_o,
  output logic              rsp_rd_o,
  output logic              rsp_wr_o,
  output logic [31:0]       rsp_paddr_o
);
  localparam int unsigned N_BANK = 2;  // index 1 = instruction, 0 = data

  logic [N_BANK-1:0][N_ENT-1:0][XW-1:0] up_q, lo_q;
  logic [N_BANK-1:0][N_ENT-1:0]         hit_v, rd_v, wr_v;
  logic [N_BANK-1:0][N_ENT-1:0][XW-1:0] pa_v;
  xlat_res_t                            bank_res [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    blk_xlate_bank #(.N_ENT(N_ENT)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i && (cfg_bank_i == (b == 1))),
      .idx_i   (cfg_idx_i),
      .lower_i (cfg_lower_i),
      .wdata_i (cfg_wdata_i),
      .upper_o (up_q[b]),
      .lower_o (lo_q[b])
    );
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      blk_xlate_entry u_ent (
        .upper_i (up_q[b][e]),
        .lower_i (lo_q[b][e]),
        .addr_i  (req_addr_i),
        .user_i  (req_user_i),
        .hit_o   (hit_v[b][e]),
        .rd_o    (rd_v[b][e]),
        .wr_o    (wr_v[b][e]),
        .paddr_o (pa_v[b][e])
      );
    end
    blk_xlate_select #(.N_ENT(N_ENT)) u_sel (
      .hit_i   (hit_v[b]),
      .rd_i    (rd_v[b]),
      .wr_i    (wr_v[b]),
      .paddr_i (pa_v[b]),
      .res_o   (bank_res[b])
    );
  end

  assign cfg_rdata_o = cfg_lower_i ? lo_q[cfg_bank_i][cfg_idx_i]
                                   : up_q[cfg_bank_i][cfg_idx_i];

  logic      xlat_on;
  xlat_res_t res_d;
  logic      fault_d;

  assign xlat_on = req_code_i ? xlat_ir_en_i : xlat_dr_en_i;

  always_comb begin
    if (!xlat_on) begin
      res_d   = '{hit: 1'b1, rd: 1'b1, wr: 1'b1, paddr: {req_addr_i[31:12], 12'h000}};
      fault_d = 1'b0;
    end else begin
      res_d   = bank_res[req_code_i];
      fault_d = res_d.hit && (req_write_i ? !res_d.wr : !res_d.rd);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_rd_o    <= 1'b0;
      rsp_wr_o    <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_hit_o   <= res_d.hit;
        rsp_fault_o <= fault_d;
        rsp_rd_o    <= res_d.rd;
        rsp_wr_o    <= res_d.wr;
        rsp_paddr_o <= res_d.paddr;
      end
    end
  end
endmodule

// File: rtl/blk_xlate_unit_chk.sv
module blk_xlate_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        xlat_ir_en_i,
  input logic        xlat_dr_en_i,
  input logic        req_i,
  input logic [31:0] req_addr_i,
  input logic        req_code_i,
  input logic        req_write_i,
  input logic        rsp_valid_o,
  input logic        rsp_hit_o,
  input logic        rsp_fault_o,
  input logic        rsp_rd_o,
  input logic        rsp_wr_o,
  input logic [31:0] rsp_paddr_o
);
  a_r12_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  a_r12_no_valid_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  a_r12_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rsp_paddr_o) && $stable(rsp_hit_o) && $stable(rsp_fault_o));

  a_r11_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !(req_code_i ? xlat_ir_en_i : xlat_dr_en_i) |=>
      rsp_hit_o && rsp_rd_o && rsp_wr_o && !rsp_fault_o &&
      rsp_paddr_o == {$past(req_addr_i[31:12]), 12'h000});

  a_r10_miss_no_rights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> !rsp_rd_o && !rsp_wr_o && !rsp_fault_o &&
      rsp_paddr_o == 32'h0);

  a_r7_write_implies_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_wr_o |-> rsp_rd_o);

  a_r6_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_paddr_o[11:0] == 12'h000);

  a_r9_fault_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_fault_o == (rsp_hit_o && ($past(req_write_i) ? !rsp_wr_o : !rsp_rd_o)));
endmodule

bind blk_xlate_unit blk_xlate_unit_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xlat_ir_en_i (xlat_ir_en_i),
  .xlat_dr_en_i (xlat_dr_en_i),
  .req_i        (req_i),
  .req_addr_i   (req_addr_i),
  .req_code_i   (req_code_i),
  .req_write_i  (req_write_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_rd_o     (rsp_rd_o),
  .rsp_wr_o     (rsp_wr_o),
  .rsp_paddr_o  (rsp_paddr_o)
);

// File: tb/blk_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module blk_xlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_bank = 1'b0, cfg_lower = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        ir_en = 1'b0, dr_en = 1'b0;
  logic        req = 1'b0, req_code = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_rd, rsp_wr;
  logic [31:0] rsp_paddr;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  always #4 clk = ~clk;

  blk_xlate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_bank_i(cfg_bank), .cfg_idx_i(cfg_idx),
    .cfg_lower_i(cfg_lower), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .xlat_ir_en_i(ir_en), .xlat_dr_en_i(dr_en),
    .req_i(req), .req_addr_i(req_addr), .req_code_i(req_code),
    .req_write_i(req_write), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
    .rsp_rd_o(rsp_rd), .rsp_wr_o(rsp_wr), .rsp_paddr_o(rsp_paddr)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected lookup result {hit, fault, rd, wr, paddr} from the requirements
  function automatic logic [35:0] exp_look(input logic [31:0] a, input logic code,
                                           input logic wr, input logic user);
    logic [31:0] u, l, bl, pa;
    logic rdok, wrok;
    int b;
    b = code ? 1 : 0;
    if (!(code ? ir_en : dr_en)) return {4'b1011, a & 32'hFFFF_F000};
    for (int i = 0; i < 4; i++) begin
      u  = m_up[b][i];
      l  = m_lo[b][i];
      bl = (u << 15) & 32'h0FFE_0000;
      if ((a & 32'hF000_0000) == (u & 32'hF000_0000) &&
          ((a & 32'h0FFE_0000) & ~bl) == (u & 32'h0FFE_0000) &&
          (user ? u[0] : u[1])) begin
        pa   = (l & 32'hF000_0000) | (a & bl) | (l & 32'h0FFE_0000) | (a & 32'h0001_F000);
        rdok = l[1] | l[0];
        wrok = l[1];
        return {1'b1, wr ? !wrok : !rdok, rdok, wrok, pa};
      end
    end
    return 36'h0;
  endfunction

  task automatic cfg_write(input logic bank, input logic [1:0] idx, input logic lo,
                           input logic [31:0] d);
    logic [31:0] m;
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = bank; cfg_idx = idx; cfg_lower = lo; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (lo) m_lo[bank][idx] = d;
    else begin
      m = (d << 15) & 32'h0FFE_0000;
      m_up[bank][idx] = (d & 32'h0000_1FFF) | (d & 32'hFFFE_0000 & ~m);
      m_lo[bank][idx] = (m_lo[bank][idx] & 32'h0000_007B) |
                        (m_lo[bank][idx] & 32'hFFFE_0000 & ~m);
    end
  endtask

  task automatic readback(input string tag);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++)
        for (int lo = 0; lo < 2; lo++) begin
          cfg_bank = b[0]; cfg_idx = i[1:0]; cfg_lower = lo[0];
          #1;
          chk(tag, {4'b0, cfg_rdata}, {4'b0, lo[0] ? m_lo[b][i] : m_up[b][i]});
        end
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic code,
                      input logic wr, input logic user);
    logic [35:0] e, got;
    string t;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_code = code; req_write = wr; req_user = user;
    e = exp_look(a, code, wr, user);
    @(negedge clk);
    req = 1'b0; req_addr = rnd();
    got = {rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_paddr};
    if (tag != "") t = tag;
    else if (!(code ? ir_en : dr_en)) t = "R11 passthrough";
    else if (!e[35]) t = "R10 miss";
    else if (e[34]) t = "R9 fault";
    else t = "R6 R7 hit";
    chk({t, " R12 valid"}, {35'h0, rsp_valid}, 36'h1);
    chk(t, got, e);
    @(negedge clk);
    chk("R12 idle hold", {rsp_valid, got[34:0]}, {1'b0, rsp_fault, rsp_rd, rsp_wr, rsp_paddr});
    chk("R12 idle hold", {35'h0, rsp_hit}, {35'h0, got[35]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base, sel, up, a;
    logic [10:0] bl;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin m_up[b][i] = '0; m_lo[b][i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_paddr}, 36'h0);
    chk("R1 reset valid", {35'h0, rsp_valid}, 36'h0);
    readback("R1 reset regs");
    rst_n = 1'b1;
    dr_en = 1'b1; ir_en = 1'b1;

    // R2: lower write stored unchanged
    cfg_write(1'b0, 2'd2, 1'b1, 32'hDEAD_BEEF);
    readback("R2 lower write");
    // R3: upper write trims stored upper and paired lower
    cfg_write(1'b0, 2'd2, 1'b0, 32'hABCD_FFFF);
    readback("R3 upper write trim");

    // R4: block length masking, data entry 0 covers 0x3450_0000 + 8 blocks
    cfg_write(1'b0, 2'd2, 1'b0, 32'h0);
    cfg_write(1'b0, 2'd0, 1'b1, 32'h8000_0002);
    cfg_write(1'b0, 2'd0, 1'b0, 32'h3450_001E);
    look("R4 inside block", 32'h3455_6789, 1'b0, 1'b0, 1'b0);
    chk("R4 inside block hit", {35'h0, rsp_hit}, 36'h1);
    look("R4 outside block", 32'h3460_0000, 1'b0, 1'b0, 1'b0);
    chk("R4 outside block miss", {35'h0, rsp_hit}, 36'h0);
    // R5: user-only entry
    cfg_write(1'b0, 2'd0, 1'b0, 32'h3450_001D);
    look("R5 supervisor denied", 32'h3450_1000, 1'b0, 1'b0, 1'b0);
    chk("R5 supervisor miss", {35'h0, rsp_hit}, 36'h0);
    look("R5 user allowed", 32'h3450_1000, 1'b0, 1'b0, 1'b1);
    chk("R5 user hit", {35'h0, rsp_hit}, 36'h1);
    // R8: entries 1 and 3 overlap, entry 1 wins
    cfg_write(1'b0, 2'd1, 1'b1, 32'h1000_0002);
    cfg_write(1'b0, 2'd1, 1'b0, 32'h7000_0003);
    cfg_write(1'b0, 2'd3, 1'b1, 32'h2000_0002);
    cfg_write(1'b0, 2'd3, 1'b0, 32'h7000_1FFF);
    look("R8 priority", 32'h7000_3000, 1'b0, 1'b1, 1'b0);
    chk("R8 lowest entry base", {4'h0, rsp_paddr}, {4'h0, 32'h1000_3000});
    // R9: read-only entry written
    cfg_write(1'b0, 2'd1, 1'b1, 32'h1000_0001);
    look("R9 write to read-only", 32'h7000_3000, 1'b0, 1'b1, 1'b0);
    chk("R9 fault flag", {34'h0, rsp_hit, rsp_fault}, 36'h3);
    // R11: passthrough and bank selection
    dr_en = 1'b0;
    look("R11 data off", 32'h7000_3ABC, 1'b0, 1'b1, 1'b1);
    dr_en = 1'b1; ir_en = 1'b1;
    look("R11 code uses instr bank", 32'h7000_3000, 1'b1, 1'b0, 1'b0);

    // Sweep over mixed configurations
    for (int t = 0; t < 300; t++) begin
      base = rnd();
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 4; i++) begin
          case (rnd() % 6)
            0: bl = 11'h000;
            1: bl = 11'h001;
            2: bl = 11'h00F;
            3: bl = 11'h0FF;
            4: bl = 11'h7FF;
            default: bl = rnd() & 11'h7FF;
          endcase
          up = ((base ^ (rnd() & 32'h0006_0000)) & 32'hFFFE_0000) |
               {19'h0, bl, 2'b00} | (rnd() & 32'h3);
          if (i == 3 && rnd()[0]) up = up ^ 32'h1000_0000;
          if (t[0]) begin
            cfg_write(b[0], i[1:0], 1'b1, rnd());
            cfg_write(b[0], i[1:0], 1'b0, up);
          end else begin
            cfg_write(b[0], i[1:0], 1'b0, up);
            cfg_write(b[0], i[1:0], 1'b1, rnd());
          end
        end
      readback(t[0] ? "R3 sweep readback" : "R2 sweep readback");
      for (int k = 0; k < 24; k++) begin
        case (rnd() % 5)
          0: sel = 32'h0001_F000;
          1: sel = 32'h0007_F000;
          2: sel = 32'h00FF_F000;
          3: sel = 32'h0FFF_F000;
          default: sel = 32'hF000_0000;
        endcase
        a = base ^ (rnd() & sel) ^ (rnd() & 32'h0000_0FFF);
        ir_en = (rnd() % 8) != 0;
        dr_en = (rnd() % 8) != 0;
        look("", a, rnd()[3], rnd()[5], rnd()[9]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule